// File: doc/BRIEF.md
# RMII Receive Byte Deframer

This block sits on the MAC side of a reduced media independent interface and runs on the continuous 50 MHz reference clock. It takes one 2-bit receive symbol per clock while the combined carrier/data-valid line is high. After carrier rises it skips any run of zero symbols. It then looks for the preamble and the start-of-frame delimiter. After the delimiter it packs the symbols into bytes and presents them with valid, first-byte and last-byte markers. A sticky receive-error flag and an alignment-error flag are reported together with the last-byte marker.

Collision is not carried on this interface, so the block rebuilds it as a plain AND of the local transmit enable and the receive carrier line. An optional input register stage is chosen by a parameter. The bytes leave one clock behind the symbol that follows them, or one clock after the clock at which carrier is seen low. This delay lets the last byte carry its end marker.

Top module: `rmii_rx_deframer`

## Requirements
- R1: One symbol is sampled per rising clock edge while `crs_dv_i` is high. Symbols are packed least-significant pair first (the first symbol after the delimiter becomes bits 1:0), and four symbols form one byte.
- R2: After carrier rises, any number of `2'b00` symbols ahead of the preamble are discarded.
- R3: While `crs_dv_i` is low, `rxd_i` is ignored, including non-zero values. No byte, first-byte marker or last-byte marker results from it.
- R4: While `crs_dv_i` is low, `rx_er_i` has no effect. It never sets the error flag of the next frame.
- R5: The preamble is a run of `2'b01` symbols, and a `2'b11` symbol ends the delimiter (0xD5). Byte alignment starts with the symbol after it. Any other non-zero symbol before the delimiter discards the whole carrier event, and no output results.
- R6: `sof_o` is high together with `byte_vld_o` on the first byte of a frame and on no other byte.
- R7: When carrier falls on a byte boundary, the final byte is presented with `eof_o` and `byte_vld_o` both high. This happens in the clock after the edge that samples `crs_dv_i` low. Each frame gives exactly one `eof_o` pulse.
- R8: An `rx_er_i` assertion on any clock with carrier high, from carrier rise to carrier fall, makes `err_o` high with the frame's `eof_o`. `err_o` is never high without `eof_o`.
- R9: When carrier falls with 1 to 3 symbols of a byte collected, the partial byte is dropped. `eof_o` then pulses with `byte_vld_o` low and `align_err_o` high. `align_err_o` is never high without `eof_o`.
- R10: `col_o` equals `tx_en_i & crs_dv_i` combinationally, without waiting for a clock.
- R11: During and after reset, `byte_vld_o`, `sof_o`, `eof_o`, `err_o` and `align_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| crs_dv_i | input | 1 | Combined carrier sense / receive data valid |
| rxd_i | input | 2 | Receive symbol |
| rx_er_i | input | 1 | Receive error from the PHY |
| tx_en_i | input | 1 | Local transmit enable, used for collision |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | `byte_o` holds a frame byte |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | End of frame; may come without a byte |
| err_o | output | 1 | Frame saw a receive error (valid with `eof_o`) |
| align_err_o | output | 1 | Frame ended off a byte boundary (valid with `eof_o`) |
| col_o | output | 1 | Rebuilt collision indication |

## Verification
The bench places leading zero runs of 0 to 30 symbols ahead of the preamble. A design that treats the first sampled symbol as preamble would abort these frames or misalign their bytes. Between frames, the idle gaps carry non-zero data and an asserted error line. A receiver that listened during carrier-low time would then emit stray bytes or flag clean frames as errored. Frames of one byte, frames with trailing partial bytes and frames with a corrupt preamble check the end-of-frame handling. A design without the one-byte hold would lose the end marker on the last byte. A design without alignment handling would emit a truncated byte.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE = 3'd0,
      RX_HUNT = 3'd1,
      RX_PRE  = 3'd2,
      RX_DATA = 3'd3,
      RX_DROP = 3'd4
   } rx_state_e;

endpackage

// File: rtl/rmii_rx_insamp.sv
module rmii_rx_insamp #(
   parameter int  DIBIT_W = 2,
   parameter bit  REG_IN  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               crs_raw,
   input  logic [DIBIT_W-1:0] d_raw,
   input  logic               er_raw,
   output logic               crs_s,
   output logic [DIBIT_W-1:0] d_s,
   output logic               er_s
);

   generate
      if (REG_IN) begin : g_reg
         logic               crs_q;
         logic [DIBIT_W-1:0] d_q;
         logic               er_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               crs_q <= 1'b0;
               d_q   <= '0;
               er_q  <= 1'b0;
            end else begin
               crs_q <= crs_raw;
               d_q   <= d_raw;
               er_q  <= er_raw;
            end
         end
         assign crs_s = crs_q;
         assign d_s   = d_q;
         assign er_s  = er_q;
      end else begin : g_thru
         assign crs_s = crs_raw;
         assign d_s   = d_raw;
         assign er_s  = er_raw;
      end
   endgenerate

endmodule

// File: rtl/rmii_rx_coldet.sv
module rmii_rx_coldet (
   input  logic tx_active,
   input  logic rx_carrier,
   output logic collision
);

   assign collision = tx_active & rx_carrier;

endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
   import rmii_rx_pkg::*;
#(
   parameter int              DIBIT_W  = 2,
   parameter int              BYTE_W   = 8,
   parameter logic [DIBIT_W-1:0] PRE_SYM = 2'b01,
   parameter logic [DIBIT_W-1:0] SFD_END = 2'b11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               crs,
   input  logic [DIBIT_W-1:0] sym,
   input  logic               er,
   output logic [BYTE_W-1:0]  byte_o,
   output logic               vld_o,
   output logic               sof_o,
   output logic               eof_o,
   output logic               err_o,
   output logic               align_o
);

   localparam int SLOTS = BYTE_W / DIBIT_W;
   localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

   rx_state_e         state_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] pend_byte_q;
   logic              pend_q;
   logic              first_q;
   logic              err_st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] assembled;

   assign assembled = {sym, shreg_q[BYTE_W-1:DIBIT_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         shreg_q     <= '0;
         pend_byte_q <= '0;
         pend_q      <= 1'b0;
         first_q     <= 1'b0;
         err_st_q    <= 1'b0;
         cnt_q       <= '0;
         byte_o      <= '0;
         vld_o       <= 1'b0;
         sof_o       <= 1'b0;
         eof_o       <= 1'b0;
         err_o       <= 1'b0;
         align_o     <= 1'b0;
      end else begin
         vld_o   <= 1'b0;
         sof_o   <= 1'b0;
         eof_o   <= 1'b0;
         err_o   <= 1'b0;
         align_o <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (crs) begin
                  err_st_q <= er;
                  if (sym == PRE_SYM)     state_q <= RX_PRE;
                  else if (sym == '0)     state_q <= RX_HUNT;
                  else                    state_q <= RX_DROP;
               end
            end
            RX_HUNT: begin
               if (!crs) begin
                  state_q <= RX_IDLE;
               end else begin
                  err_st_q <= err_st_q | er;
                  if (sym == PRE_SYM)     state_q <= RX_PRE;
                  else if (sym != '0)     state_q <= RX_DROP;
               end
            end
            RX_PRE: begin
               if (!crs) begin
                  state_q <= RX_IDLE;
               end else begin
                  err_st_q <= err_st_q | er;
                  if (sym == SFD_END) begin
                     state_q <= RX_DATA;
                     cnt_q   <= '0;
                     first_q <= 1'b1;
                     pend_q  <= 1'b0;
                  end else if (sym != PRE_SYM) begin
                     state_q <= RX_DROP;
                  end
               end
            end
            RX_DATA: begin
               if (!crs) begin
                  state_q <= RX_IDLE;
                  eof_o   <= 1'b1;
                  vld_o   <= pend_q;
                  sof_o   <= pend_q & first_q;
                  byte_o  <= pend_byte_q;
                  err_o   <= err_st_q;
                  align_o <= (cnt_q != '0);
                  pend_q  <= 1'b0;
               end else begin
                  err_st_q <= err_st_q | er;
                  shreg_q  <= assembled;
                  if (pend_q) begin
                     vld_o   <= 1'b1;
                     sof_o   <= first_q;
                     byte_o  <= pend_byte_q;
                     first_q <= 1'b0;
                     pend_q  <= 1'b0;
                  end
                  if (cnt_q == LAST_SLOT) begin
                     cnt_q       <= '0;
                     pend_q      <= 1'b1;
                     pend_byte_q <= assembled;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_DROP: begin
               if (!crs) state_q <= RX_IDLE;
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R6
   sof_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |-> vld_o);

   // R7
   eof_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> !$past(crs));

   // R8
   err_only_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> eof_o);

   // R9
   align_only_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_o |-> (eof_o && !vld_o));

   // R3
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_IDLE && !crs) |=> !(vld_o || eof_o));

endmodule

// File: rtl/rmii_rx_deframer.sv
module rmii_rx_deframer #(
   parameter int DIBIT_W = 2,
   parameter int BYTE_W  = 8,
   parameter bit REG_IN  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              crs_dv_i,
   input  logic [1:0]        rxd_i,
   input  logic              rx_er_i,
   input  logic              tx_en_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic              sof_o,
   output logic              eof_o,
   output logic              err_o,
   output logic              align_err_o,
   output logic              col_o
);

   generate
      if (DIBIT_W != 2) begin : g_bad_sym
         $error("rmii_rx_deframer: symbol width must be 2");
      end
      if (BYTE_W % DIBIT_W != 0 || BYTE_W < DIBIT_W) begin : g_bad_byte
         $error("rmii_rx_deframer: byte width must be a multiple of symbol width");
      end
   endgenerate

   logic               crs_s;
   logic [DIBIT_W-1:0] sym_s;
   logic               er_s;

   rmii_rx_insamp #(.DIBIT_W(DIBIT_W), .REG_IN(REG_IN)) u_insamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .crs_raw (crs_dv_i),
      .d_raw   (rxd_i),
      .er_raw  (rx_er_i),
      .crs_s   (crs_s),
      .d_s     (sym_s),
      .er_s    (er_s)
   );

   rmii_rx_framer #(.DIBIT_W(DIBIT_W), .BYTE_W(BYTE_W)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .crs     (crs_s),
      .sym     (sym_s),
      .er      (er_s),
      .byte_o  (byte_o),
      .vld_o   (byte_vld_o),
      .sof_o   (sof_o),
      .eof_o   (eof_o),
      .err_o   (err_o),
      .align_o (align_err_o)
   );

   rmii_rx_coldet u_coldet (
      .tx_active  (tx_en_i),
      .rx_carrier (crs_dv_i),
      .collision  (col_o)
   );

endmodule

// File: tb/test_rmii_rx_deframer.sv
module test_rmii_rx_deframer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       crs_dv_i = 1'b0;
   logic [1:0] rxd_i = 2'b00;
   logic       rx_er_i = 1'b0;
   logic       tx_en_i = 1'b0;
   logic [7:0] byte_o;
   logic       byte_vld_o, sof_o, eof_o, err_o, align_err_o, col_o;

   always #10 clk = ~clk;

   rmii_rx_deframer i_rmii_rx_deframer (
      .clk(clk), .rst_n(rst_n), .crs_dv_i(crs_dv_i), .rxd_i(rxd_i),
      .rx_er_i(rx_er_i), .tx_en_i(tx_en_i), .byte_o(byte_o),
      .byte_vld_o(byte_vld_o), .sof_o(sof_o), .eof_o(eof_o),
      .err_o(err_o), .align_err_o(align_err_o), .col_o(col_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // capture of outputs, taken at the falling edge
   logic [7:0] rx_b [64];
   bit         rx_s [64];
   int nrx = 0, eof_cnt = 0;
   bit eof_byte = 0, eof_err = 0, eof_al = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_vld_o && nrx < 64) begin
            rx_b[nrx] = byte_o;
            rx_s[nrx] = sof_o;
            nrx++;
         end
         if (eof_o) begin
            eof_cnt++;
            eof_byte = byte_vld_o;
            eof_err  = err_o;
            eof_al   = align_err_o;
         end
      end
   end

   task automatic clr_cap();
      nrx = 0; eof_cnt = 0; eof_byte = 0; eof_err = 0; eof_al = 0;
   endtask

   task automatic step(input bit c, input logic [1:0] d, input bit e);
      @(negedge clk);
      crs_dv_i = c; rxd_i = d; rx_er_i = e;
   endtask

   // idle gap with noisy data and error line (must be ignored: R3, R4)
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'(i % 3 + 1), 1'b1);
   endtask

   function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
      return seed + 8'(i * 37);
   endfunction

   task automatic send(input int lead, input int pre, input int nb,
                       input logic [7:0] seed, input int erpos, input int extra);
      int k = 0;
      for (int i = 0; i < lead; i++) begin step(1'b1, 2'b00, k == erpos); k++; end
      for (int i = 0; i < pre; i++)  begin step(1'b1, 2'b01, k == erpos); k++; end
      step(1'b1, 2'b11, k == erpos); k++;
      for (int b = 0; b < nb; b++) begin
         logic [7:0] v = pay(seed, b);
         for (int s = 0; s < 4; s++) begin
            step(1'b1, v[2*s +: 2], k == erpos); k++;
         end
      end
      for (int i = 0; i < extra; i++) begin step(1'b1, 2'b10, k == erpos); k++; end
      idle(4);
   endtask

   // lead, pre, nbytes, seed, error position (255 = none), extra symbols
   localparam int NV = 7;
   localparam logic [47:0] VEC [NV] = '{
      {8'd0,  8'd7,  8'd4, 8'h11, 8'd255, 8'd0},
      {8'd5,  8'd7,  8'd6, 8'hA0, 8'd255, 8'd0},
      {8'd12, 8'd3,  8'd2, 8'h3C, 8'd20,  8'd0},
      {8'd2,  8'd15, 8'd1, 8'h5A, 8'd255, 8'd0},
      {8'd1,  8'd7,  8'd3, 8'h77, 8'd255, 8'd2},
      {8'd0,  8'd1,  8'd5, 8'hC3, 8'd0,   8'd0},
      {8'd30, 8'd7,  8'd8, 8'h01, 8'd255, 8'd1}
   };

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      // R11 reset state
      chk("R11 vld", byte_vld_o, 0);
      chk("R11 eof", eof_o, 0);
      chk("R11 flags", {sof_o, err_o, align_err_o}, 0);
      rst_n = 1'b1;
      idle(5);
      chk("R3 R4 no output in idle", nrx + eof_cnt, 0);

      for (int v = 0; v < NV; v++) begin
         int lead  = int'(VEC[v][47:40]);
         int pre   = int'(VEC[v][39:32]);
         int nb    = int'(VEC[v][31:24]);
         logic [7:0] seed = VEC[v][23:16];
         int erpos = (VEC[v][15:8] == 8'd255) ? -1 : int'(VEC[v][15:8]);
         int extra = int'(VEC[v][7:0]);
         clr_cap();
         send(lead, pre, nb, seed, erpos, extra);
         // R1 R2 R3 byte count and values
         chk("R2 R3 byte count", nrx, nb);
         for (int b = 0; b < nb && b < nrx; b++) begin
            chk("R1 byte value", rx_b[b], pay(seed, b));
            chk("R6 sof marker", rx_s[b], b == 0);
         end
         chk("R7 one eof", eof_cnt, 1);
         chk("R7 R9 eof with byte", eof_byte, extra == 0);
         chk("R8 R4 error flag", eof_err, erpos >= 0);
         chk("R9 alignment flag", eof_al, extra != 0);
      end

      // R5 corrupt preamble symbol discards the event
      clr_cap();
      for (int i = 0; i < 4; i++) step(1'b1, 2'b01, 1'b0);
      step(1'b1, 2'b10, 1'b0);
      step(1'b1, 2'b01, 1'b0);
      step(1'b1, 2'b11, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, 2'b01, 1'b0);
      idle(4);
      chk("R5 bad preamble no bytes", nrx, 0);
      chk("R5 bad preamble no eof", eof_cnt, 0);

      // R5 carrier lost inside preamble
      clr_cap();
      for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b1, 2'b01, 1'b0);
      idle(4);
      chk("R5 carrier drop in preamble", nrx + eof_cnt, 0);

      // R9 carrier drops right after delimiter plus one symbol
      clr_cap();
      send(0, 3, 0, 8'h00, -1, 1);
      chk("R9 no byte", nrx, 0);
      chk("R9 eof align", {eof_cnt[1:0], eof_al}, {2'd1, 1'b1});

      // R10 collision is a live AND
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         tx_en_i = i[0]; crs_dv_i = i[1]; rxd_i = 2'b00;
         #1;
         chk("R10 collision", col_o, i[0] & i[1]);
      end
      tx_en_i = 1'b0; crs_dv_i = 1'b0;
      idle(4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule